// File: doc/BRIEF.md
# Vector Compare and Masked Element Unit

This block runs two kinds of vector instruction, one element per clock. A compare instruction checks each element of an operand stream against a scalar and stores one bit per element in a mask register. An arithmetic instruction subtracts or adds two operand streams element by element. It updates an element only where the stored mask allows, so a compare followed by a masked subtract carries out a conditional loop body without branches.

An instruction is issued with a one-cycle `start` pulse. The pulse carries the opcode, the vector length and the scalar. The operand elements then arrive in order, one on each cycle that `in_valid` is high. The destination of an arithmetic instruction is the first operand. Each result leaves on the result port together with a write enable. An element that the mask disables is still sent out, with its old value and the write enable low, so it still uses its issue slot. The mask register can be read at all times on `mask_out`.

Top module: `vcm_unit`

## Requirements
- R1: Opcode 0 (compare-not-equal) sets mask bit i to 1 when operand element i differs from the scalar, and to 0 when the two are equal, for every i below the vector length.
- R2: Opcode 1 (compare-equal) sets mask bit i to 1 when element i equals the scalar, and to 0 otherwise.
- R3: A compare clears every mask bit at an index at or above its vector length.
- R4: Opcodes 2 (masked subtract) and 3 (masked add) produce a-b or a+b, modulo 2^DATA_W, with `res_we`=1 for each element whose mask bit is 1.
- R5: For a masked opcode, an element whose mask bit is 0 is still emitted with `res_valid`. It carries `res_we`=0 and `res_data` equal to its unchanged first operand.
- R6: Opcodes 4 (subtract) and 5 (add) ignore the mask and behave as if every mask bit were 1.
- R7: Each cycle in which the unit is busy and `in_valid` is high consumes one element. Its result appears on the next cycle with `res_idx` equal to the element's position. A cycle with `in_valid` low produces no result.
- R8: `done` pulses for one cycle, and `busy` drops, on the cycle after the last element is consumed. A length of 0 gives `done` on the cycle after `start`, and the unit never becomes busy. A length above MAX_VL is treated as MAX_VL.
- R9: A masked instruction issued on the cycle that `done` of a compare is high uses that compare's mask, with no idle cycle between the two.
- R10: `start` is ignored while busy, and `start` with opcode 6 or 7 is ignored. Arithmetic instructions never change the mask.
- R11: After reset, `busy`, `done` and `res_valid` are 0 and the mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue pulse, sampled while idle |
| opcode | input | 3 | Instruction selector (0..5 legal) |
| vlen | input | LEN_W | Vector length for this instruction |
| scalar | input | DATA_W | Scalar for compares |
| in_valid | input | 1 | Operand element present |
| a_elem | input | DATA_W | First operand element (also destination's old value) |
| b_elem | input | DATA_W | Second operand element |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| res_valid | output | 1 | Result element present |
| res_we | output | 1 | Result element is to be written |
| res_idx | output | IDX_W | Element position of the result |
| res_data | output | DATA_W | Result element value |
| mask_out | output | MAX_VL | Mask register contents |

## Verification
An arithmetic result is due exactly one cycle after the edge that consumes its element. The driver pushes the expected entry just before that edge, and the monitor pops it at the falling edge after that edge. Stall cycles therefore shift the results without making them go out of order. A mask bit settles at the edge that consumes its element, so the mask is compared in the cycle where `done` is high, one cycle after the last consume edge, and the busy, done and mask checks for ignored issues fall in that same cycle. The next instruction starts in that cycle too, which exercises the compare-to-masked hand-off with no gap.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

  typedef enum logic [2:0] {
    OP_CMP_NE = 3'd0,
    OP_CMP_EQ = 3'd1,
    OP_SUB_M  = 3'd2,
    OP_ADD_M  = 3'd3,
    OP_SUB    = 3'd4,
    OP_ADD    = 3'd5
  } vcm_op_e;

  function automatic logic op_legal(input logic [2:0] op);
    return (op <= 3'd5);
  endfunction

  function automatic logic op_is_cmp(input logic [2:0] op);
    return (op == OP_CMP_NE) || (op == OP_CMP_EQ);
  endfunction

  function automatic logic op_uses_mask(input logic [2:0] op);
    return (op == OP_SUB_M) || (op == OP_ADD_M);
  endfunction

  function automatic logic op_is_sub(input logic [2:0] op);
    return (op == OP_SUB_M) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/vcm_ctrl.sv
module vcm_ctrl #(
  parameter int MAX_VL = 64,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [LEN_W-1:0]  vlen,
  input  logic [DATA_W-1:0] scalar,
  input  logic              in_valid,
  output logic              accept,
  output logic              consume,
  output logic              busy,
  output logic              done,
  output logic [2:0]        op_q,
  output logic [DATA_W-1:0] scal_q,
  output logic [IDX_W-1:0]  idx_q
);
  import vcm_pkg::*;

  logic [LEN_W-1:0] vl_q;
  logic [LEN_W-1:0] vl_eff;
  logic             last;

  assign vl_eff  = (vlen > LEN_W'(MAX_VL)) ? LEN_W'(MAX_VL) : vlen;
  assign accept  = start && !busy && op_legal(opcode);
  assign consume = busy && in_valid;
  assign last    = ({1'b0, idx_q} + LEN_W'(1)) == vl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      op_q   <= 3'd0;
      scal_q <= '0;
      idx_q  <= '0;
      vl_q   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q   <= opcode;
        scal_q <= scalar;
        vl_q   <= vl_eff;
        idx_q  <= '0;
        busy   <= (vl_eff != '0);
        done   <= (vl_eff == '0);
      end else if (consume) begin
        idx_q <= idx_q + IDX_W'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vcm_mask.sv
module vcm_mask #(
  parameter int MAX_VL = 64,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              set_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit,
  output logic [MAX_VL-1:0] mask_q
);

  for (genvar i = 0; i < MAX_VL; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear)
        mask_q[i] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(i)))
        mask_q[i] <= set_val;
    end
  end

  assign rd_bit = mask_q[rd_idx];

endmodule

// File: rtl/vcm_lane.sv
module vcm_lane #(
  parameter int MAX_VL = 64,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [2:0]        op,
  input  logic              mask_bit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              res_valid,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data
);
  import vcm_pkg::*;

  logic              enable;
  logic [DATA_W-1:0] sum;

  assign enable = op_uses_mask(op) ? mask_bit : 1'b1;
  assign sum    = op_is_sub(op) ? (a - b) : (a + b);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_we    <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_we   <= enable;
        res_idx  <= idx;
        res_data <= enable ? sum : a;
      end else begin
        res_we <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vcm_unit.sv
module vcm_unit #(
  parameter int MAX_VL = 64,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int LEN_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [LEN_W-1:0]  vlen,
  input  logic [DATA_W-1:0] scalar,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] a_elem,
  input  logic [DATA_W-1:0] b_elem,
  output logic              busy,
  output logic              done,
  output logic              res_valid,
  output logic              res_we,
  output logic [IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0] res_data,
  output logic [MAX_VL-1:0] mask_out
);
  import vcm_pkg::*;

  logic              accept, consume;
  logic [2:0]        op_q;
  logic [DATA_W-1:0] scal_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cmp_hit, mask_bit;

  vcm_ctrl #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .vlen(vlen),
    .scalar(scalar), .in_valid(in_valid), .accept(accept), .consume(consume),
    .busy(busy), .done(done), .op_q(op_q), .scal_q(scal_q), .idx_q(idx_q)
  );

  assign cmp_hit = (op_q == OP_CMP_EQ) ? (a_elem == scal_q) : (a_elem != scal_q);

  vcm_mask #(.MAX_VL(MAX_VL)) u_mask (
    .clk(clk), .rst(rst),
    .clear(accept && op_is_cmp(opcode)),
    .set_en(consume && op_is_cmp(op_q)),
    .set_idx(idx_q), .set_val(cmp_hit),
    .rd_idx(idx_q), .rd_bit(mask_bit), .mask_q(mask_out)
  );

  vcm_lane #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) u_lane (
    .clk(clk), .rst(rst),
    .fire(consume && !op_is_cmp(op_q)),
    .op(op_q), .mask_bit(mask_bit), .idx(idx_q),
    .a(a_elem), .b(b_elem),
    .res_valid(res_valid), .res_we(res_we), .res_idx(res_idx), .res_data(res_data)
  );

endmodule

module vcm_unit_chk #(
  parameter int MAX_VL = 64,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        opcode,
  input logic              in_valid,
  input logic [DATA_W-1:0] a_elem,
  input logic              busy,
  input logic              done,
  input logic              res_valid,
  input logic              res_we,
  input logic [DATA_W-1:0] res_data,
  input logic [MAX_VL-1:0] mask_out
);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !res_valid && mask_out == '0));

  // R7
  result_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(busy && in_valid));

  // R7
  stall_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !in_valid) |=> !res_valid);

  // R5
  masked_off_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_we) |-> (res_data == $past(a_elem)));

  // R10
  arith_keeps_mask_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $stable(mask_out));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  illegal_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && opcode[2:1] == 2'b11) |=> (!busy && !done && $stable(mask_out)));

endmodule

bind vcm_unit vcm_unit_chk #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode), .in_valid(in_valid),
  .a_elem(a_elem), .busy(busy), .done(done), .res_valid(res_valid),
  .res_we(res_we), .res_data(res_data), .mask_out(mask_out)
);

// File: tb/vcm_unit_tb.sv
module vcm_unit_tb;
  localparam int MAX_VL = 64;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 6;
  localparam int LEN_W  = 7;

  typedef struct {
    int          idx;
    logic        we;
    logic [15:0] data;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] opcode = '0;
  logic [LEN_W-1:0] vlen = '0;
  logic [DATA_W-1:0] scalar = '0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] a_elem = '0, b_elem = '0;
  logic busy, done, res_valid, res_we;
  logic [IDX_W-1:0] res_idx;
  logic [DATA_W-1:0] res_data;
  logic [MAX_VL-1:0] mask_out;

  int n_cmp = 0, n_bad = 0;
  exp_t sb[$];
  logic [15:0] va [64];
  logic [15:0] vb [64];
  logic [63:0] model_mask = '0;

  always #5 clk = ~clk;

  vcm_unit #(.MAX_VL(MAX_VL), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .vlen(vlen),
    .scalar(scalar), .in_valid(in_valid), .a_elem(a_elem), .b_elem(b_elem),
    .busy(busy), .done(done), .res_valid(res_valid), .res_we(res_we),
    .res_idx(res_idx), .res_data(res_data), .mask_out(mask_out)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as results emerge
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7 unexpected result", {58'd0, res_idx}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_idx == IDX_W'(e.idx), {e.tag, " idx"}, {58'd0, res_idx}, 64'(e.idx));
        chk(res_we == e.we, {e.tag, " we"}, {63'd0, res_we}, {63'd0, e.we});
        chk(res_data == e.data, {e.tag, " data"}, {48'd0, res_data}, {48'd0, e.data});
      end
    end
  end

  task automatic fill(input int seed, input logic [15:0] s);
    for (int k = 0; k < 64; k++) begin
      va[k] = (k % 3 == 0) ? s : 16'((k * 2341 + seed * 97) & 16'hFFFF);
      vb[k] = 16'((k * 7919 + seed * 13) & 16'hFFFF);
    end
  endtask

  // driver: issue one instruction, stream elements, push expectations
  task automatic issue(input logic [2:0] op, input int vl, input logic [15:0] s,
                       input int stall_mod, input int poke_at);
    int vle;
    vle = (vl > 64) ? 64 : vl;
    start = 1'b1; opcode = op; vlen = LEN_W'(vl); scalar = s;
    @(posedge clk); #1;
    start = 1'b0;
    if (op <= 3'd1) model_mask = '0;
    for (int k = 0; k < vle; k++) begin
      if (stall_mod > 0 && (k % stall_mod) == 1) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1; a_elem = va[k]; b_elem = vb[k];
      start = (k == poke_at); opcode = (k == poke_at) ? 3'd0 : op;
      if (op == 3'd0) model_mask[k] = (va[k] != s);
      else if (op == 3'd1) model_mask[k] = (va[k] == s);
      else begin
        exp_t e;
        logic en;
        en = (op >= 3'd4) ? 1'b1 : model_mask[k];
        e.idx = k; e.we = en;
        e.data = !en ? va[k] : ((op == 3'd2 || op == 3'd4) ? va[k] - vb[k] : va[k] + vb[k]);
        e.tag = (op >= 3'd4) ? "R6" : (en ? "R4" : "R5");
        sb.push_back(e);
      end
      @(posedge clk); #1;
      start = 1'b0;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R8 done/busy after last", {62'd0, done, busy}, 64'b10);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !res_valid, "R11 flags", {61'd0, busy, done, res_valid}, 64'd0);
    chk(mask_out == '0, "R11 mask", mask_out, 64'd0);

    // R1 compare-not-equal over full length, then R3 shorter compare clears upper bits
    fill(1, 16'h0005);
    issue(3'd0, 64, 16'h0005, 0, -1);
    chk(mask_out == model_mask, "R1 mask ne full", mask_out, model_mask);
    fill(2, 16'h0005);
    issue(3'd0, 20, 16'h0005, 0, -1);
    chk(mask_out == model_mask, "R3 mask cleared above vl", mask_out, model_mask);

    // R9 masked subtract issued in the done cycle; R4/R5 via scoreboard
    issue(3'd2, 20, 16'h0, 0, -1);
    chk(mask_out == model_mask, "R10 mask kept after sub", mask_out, model_mask);

    // R4/R5/R7 masked add with stall cycles
    fill(3, 16'h0005);
    issue(3'd3, 20, 16'h0, 3, -1);

    // R2 compare-equal
    fill(4, 16'h0007);
    issue(3'd1, 64, 16'h0007, 0, -1);
    chk(mask_out == model_mask, "R2 mask eq", mask_out, model_mask);

    // R8 length above limit is clamped
    fill(5, 16'h1234);
    issue(3'd0, 70, 16'h1234, 0, -1);
    chk(mask_out == model_mask, "R8 clamp mask", mask_out, model_mask);

    // R6 unmasked subtract and add ignore mask (mask has clear bits)
    fill(6, 16'h0);
    issue(3'd4, 30, 16'h0, 0, -1);
    issue(3'd5, 25, 16'h0, 2, -1);

    // R10 start during busy masked add is ignored
    fill(7, 16'h0009);
    issue(3'd3, 16, 16'h0, 0, 4);
    chk(mask_out == model_mask, "R10 mask after poke", mask_out, model_mask);

    // R10 illegal opcode ignored
    start = 1'b1; opcode = 3'd6; vlen = 7'd8;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R10 illegal opcode", {62'd0, busy, done}, 64'd0);
    chk(mask_out == model_mask, "R10 illegal mask", mask_out, model_mask);

    // R8 zero length compare: done next cycle, mask cleared (R3)
    start = 1'b1; opcode = 3'd0; vlen = 7'd0; scalar = 16'h0;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R8 zero length", {62'd0, done, busy}, 64'b10);
    chk(mask_out == '0, "R3 zero length clears", mask_out, 64'd0);

    repeat (3) @(posedge clk);
    chk(sb.size() == 0, "R7 all results seen", 64'(sb.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule